// File: doc/BRIEF.md
# PHY Control-Port Handshake Master

This block turns single commands from a simple request interface into the strobe-and-acknowledge traffic of a PHY's parallel control-register port. There are three commands: addressing, write and read. For each one the block places a 16-bit value on the port's data field. It then steps the strobes the command needs through a four-phase handshake. After every strobe edge it polls the port's acknowledge until the acknowledge follows the strobe.

The time between polls comes from a programmable interval counter. The number of polls for each edge is bounded. If the acknowledge never arrives, the command ends with a timeout error and every strobe is dropped. A write whose data has bit 0 set tells the PHY to reset itself. While it resets, the PHY cannot acknowledge, so the block raises the write strobe and completes the command without waiting. The PHY itself is not part of the block.

Top module: `phy_cr_master`

## Requirements
- R1: After reset `busy`, `done`, `timeout_err`, `rd_data` and the whole `phy_ctrl` word are 0.
- R2: A request is taken only when `req_valid` is high while `busy` is low. A request raised while busy has no effect: no extra strobe and no change of the driven value. Command code 2'b00 is addressing, 2'b01 is write, 2'b10 is read, and 2'b11 completes with no strobe.
- R3: An addressing command drives the value on `phy_ctrl[15:0]`. It raises capture-address (`phy_ctrl[16]`) until acknowledge is seen high, then lowers it until acknowledge is seen low.
- R4: A write command runs the same four-phase handshake on capture-data (`phy_ctrl[17]`) and then on write (`phy_ctrl[18]`). The PHY register selected by the last address then holds the data.
- R5: A read command raises read (`phy_ctrl[19]`). When acknowledge is seen high, it stores `phy_stat[15:0]` in `rd_data`. It then lowers read until acknowledge is seen low.
- R6: Acknowledge is `phy_stat[18]`. It is polled once every `poll_interval` cycles, with 0 treated as 1, for at most 10 polls per strobe edge. An edge that is never acknowledged keeps `busy` high for exactly 10×interval+2 cycles, counting the `done` cycle.
- R7: On timeout, `done` and `timeout_err` rise together, all strobes are low, and no later strobe of that command is issued.
- R8: A write with data bit 0 set raises the write strobe and completes without waiting for acknowledge and without error. The strobe stays high until the next command is accepted.
- R9: `busy` stays high from acceptance through the single cycle in which `done` is high. `done` never lasts two cycles. `timeout_err` holds until the next acceptance.
- R10: At most one strobe is high at any time, and `phy_ctrl[15:0]` does not change while a command is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command request |
| req_cmd | input | 2 | Command code |
| req_data | input | 16 | Address or write data |
| poll_interval | input | 8 | Cycles between acknowledge polls (0 acts as 1) |
| busy | output | 1 | Command in flight |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Last command timed out |
| rd_data | output | 16 | Data captured by the last read |
| phy_ctrl | output | 20 | PHY control word: value in [15:0], strobes in [19:16] |
| phy_stat | input | 19 | PHY status word: data in [15:0], acknowledge in [18] |

## Verification
The assertions assume that `poll_interval` stays constant while a command is in flight. They also assume that the PHY side never drives the control word, so the value and the strobe levels come only from the block. The bench changes the interval and the responder's acknowledge delay or stuck mode only between commands, after `done`. It gives the responder a short settling gap before the next request. It also holds the write strobe of a reset write unacknowledged, as a resetting PHY would.

// File: rtl/phy_cr_pkg.sv
// Shared types for the PHY control-port handshake master.
// Assumes four strobes in a fixed order that the PHY decodes by position.
package phy_cr_pkg;

    localparam int STROBE_N = 4;

    typedef enum logic [1:0] {
        CMD_ADDR  = 2'b00,
        CMD_WRITE = 2'b01,
        CMD_READ  = 2'b10,
        CMD_NOP   = 2'b11
    } cmd_e;

    // Strobe index: offset from the lowest strobe bit of the control word.
    typedef enum logic [1:0] {
        SB_CAP_ADDR = 2'd0,
        SB_CAP_DATA = 2'd1,
        SB_WRITE    = 2'd2,
        SB_READ     = 2'd3
    } strobe_e;

    // One step of a command: drive a strobe to a level, then wait for ack.
    typedef struct packed {
        strobe_e sel;
        logic    level;
        logic    last;
        logic    no_wait;
        logic    capture;
    } step_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EDGE,
        ST_WAIT,
        ST_FINISH
    } state_e;

endpackage

// File: rtl/phy_cr_poll_timer.sv
// Poll interval counter.
// Raises tick once every `interval` cycles while run is high (0 acts as 1).
// Assumes interval stays constant between load and the end of the wait.
module phy_cr_poll_timer #(
    parameter int IV_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            run,
    input  logic [IV_W-1:0] interval,
    output logic            tick
);

    logic [IV_W-1:0] cnt;
    logic [IV_W-1:0] reload;
    logic [IV_W-1:0] iv_eff;

    // Clamp a zero interval to one cycle.
    always_comb iv_eff = (interval == '0) ? IV_W'(1) : interval;

    // Count down, reloading after each tick; park at zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            reload <= IV_W'(1);
        end else if (load) begin
            cnt    <= iv_eff;
            reload <= iv_eff;
        end else if (run) begin
            if (cnt == IV_W'(1)) cnt <= reload;
            else if (cnt != '0) cnt <= cnt - IV_W'(1);
        end else begin
            cnt <= '0;
        end
    end

    // Tick on the last cycle of each interval.
    always_comb tick = run && (cnt == IV_W'(1));

endmodule

// File: rtl/phy_cr_step_dec.sv
// Step decoder: maps (command, step index) to the strobe action of that step.
// A write whose data has bit 0 set ends on the raised write strobe, with no wait.
module phy_cr_step_dec
    import phy_cr_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  cmd_e             cmd,
    input  logic [IDX_W-1:0] idx,
    input  logic             reset_write,
    output step_t            step,
    output logic             step_valid
);

    // Build the step for the current command and index.
    always_comb begin
        step       = '{sel: SB_CAP_ADDR, level: 1'b0, last: 1'b0, no_wait: 1'b0, capture: 1'b0};
        step_valid = 1'b1;
        unique case (cmd)
            CMD_ADDR: begin
                step.sel   = SB_CAP_ADDR;
                step.level = (idx == IDX_W'(0));
                step.last  = (idx == IDX_W'(1));
            end
            CMD_WRITE: begin
                step.sel   = (idx < IDX_W'(2)) ? SB_CAP_DATA : SB_WRITE;
                step.level = !idx[0];
                if (idx == IDX_W'(2) && reset_write) begin
                    step.last    = 1'b1;
                    step.no_wait = 1'b1;
                end else begin
                    step.last = (idx == IDX_W'(3));
                end
            end
            CMD_READ: begin
                step.sel     = SB_READ;
                step.level   = (idx == IDX_W'(0));
                step.capture = (idx == IDX_W'(0));
                step.last    = (idx == IDX_W'(1));
            end
            default: step_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/phy_cr_seq.sv
// Command sequencer: accepts one command at a time, runs each strobe step
// through an edge and a bounded acknowledge wait, and reports completion.
// Assumes the timer ticks once per poll and the ack input is synchronous.
module phy_cr_seq
    import phy_cr_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MAX_POLLS = 10,
    parameter int IDX_W     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  cmd_e                req_cmd,
    input  logic [DATA_W-1:0]   req_data,
    input  logic                ack,
    input  logic [DATA_W-1:0]   stat_data,
    input  logic                tick,
    input  step_t               step,
    input  logic                step_valid,
    output cmd_e                cmd_q,
    output logic [DATA_W-1:0]   data_q,
    output logic [IDX_W-1:0]    step_idx,
    output logic                timer_load,
    output logic                timer_run,
    output logic [STROBE_N-1:0] strobes,
    output logic                busy,
    output logic                done,
    output logic                timeout_err,
    output logic [DATA_W-1:0]   rd_data
);

    localparam int PW = $clog2(MAX_POLLS + 1);

    state_e        state;
    logic [PW-1:0] polls;

    // Main command state machine and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cmd_q       <= CMD_NOP;
            data_q      <= '0;
            step_idx    <= '0;
            polls       <= '0;
            strobes     <= '0;
            timeout_err <= 1'b0;
            rd_data     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cmd_q       <= req_cmd;
                        data_q      <= req_data;
                        step_idx    <= '0;
                        strobes     <= '0;
                        timeout_err <= 1'b0;
                        state       <= ST_EDGE;
                    end
                end
                ST_EDGE: begin
                    polls <= '0;
                    if (!step_valid) begin
                        state <= ST_FINISH;
                    end else begin
                        strobes[step.sel] <= step.level;
                        state <= step.no_wait ? ST_FINISH : ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (tick) begin
                        if (ack == step.level) begin
                            if (step.capture) rd_data <= stat_data;
                            if (step.last) begin
                                state <= ST_FINISH;
                            end else begin
                                step_idx <= step_idx + IDX_W'(1);
                                state    <= ST_EDGE;
                            end
                        end else if (polls == PW'(MAX_POLLS - 1)) begin
                            strobes     <= '0;
                            timeout_err <= 1'b1;
                            state       <= ST_FINISH;
                        end else begin
                            polls <= polls + PW'(1);
                        end
                    end
                end
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // State-decoded handshake outputs and timer controls.
    always_comb begin
        busy       = (state != ST_IDLE);
        done       = (state == ST_FINISH);
        timer_load = (state == ST_EDGE);
        timer_run  = (state == ST_WAIT);
    end

endmodule

// File: rtl/phy_cr_master.sv
// Top level of the PHY control-port handshake master.
// Packs the driven value and strobes into the control word and extracts the
// acknowledge and read data from the status word. Assumes ACK_BIT >= DATA_W
// and STROBE_LSB >= DATA_W, so the fields never overlap.
module phy_cr_master
    import phy_cr_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int STROBE_LSB = 16,
    parameter int ACK_BIT    = 18,
    parameter int MAX_POLLS  = 10,
    parameter int IV_W       = 8,
    localparam int CTRL_W    = STROBE_LSB + STROBE_N,
    localparam int STAT_W    = ACK_BIT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [DATA_W-1:0] req_data,
    input  logic [IV_W-1:0]   poll_interval,
    output logic              busy,
    output logic              done,
    output logic              timeout_err,
    output logic [DATA_W-1:0] rd_data,
    output logic [CTRL_W-1:0] phy_ctrl,
    input  logic [STAT_W-1:0] phy_stat
);

    localparam int IDX_W = 3;

    cmd_e                cmd_q;
    logic [DATA_W-1:0]   data_q;
    logic [IDX_W-1:0]    step_idx;
    logic                timer_load;
    logic                timer_run;
    logic                tick;
    logic [STROBE_N-1:0] strobes;
    step_t               step;
    logic                step_valid;

    phy_cr_step_dec #(.IDX_W(IDX_W)) u_dec (
        .cmd         (cmd_q),
        .idx         (step_idx),
        .reset_write (data_q[0]),
        .step        (step),
        .step_valid  (step_valid)
    );

    phy_cr_poll_timer #(.IV_W(IV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .run      (timer_run),
        .interval (poll_interval),
        .tick     (tick)
    );

    phy_cr_seq #(
        .DATA_W    (DATA_W),
        .MAX_POLLS (MAX_POLLS),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_cmd     (cmd_e'(req_cmd)),
        .req_data    (req_data),
        .ack         (phy_stat[ACK_BIT]),
        .stat_data   (phy_stat[DATA_W-1:0]),
        .tick        (tick),
        .step        (step),
        .step_valid  (step_valid),
        .cmd_q       (cmd_q),
        .data_q      (data_q),
        .step_idx    (step_idx),
        .timer_load  (timer_load),
        .timer_run   (timer_run),
        .strobes     (strobes),
        .busy        (busy),
        .done        (done),
        .timeout_err (timeout_err),
        .rd_data     (rd_data)
    );

    // Value field of the control word.
    assign phy_ctrl[DATA_W-1:0] = data_q;

    // Strobe field: one bit per strobe, at fixed positions.
    for (genvar i = 0; i < STROBE_N; i++) begin : g_strobe
        assign phy_ctrl[STROBE_LSB + i] = strobes[i];
    end

    // Any gap between the value and strobe fields is tied low.
    if (STROBE_LSB > DATA_W) begin : g_ctrl_gap
        assign phy_ctrl[STROBE_LSB-1:DATA_W] = '0;
    end

    // Status bits between the data and ack fields carry no meaning here.
    if (ACK_BIT > DATA_W) begin : g_stat_gap
        logic unused_stat;
        assign unused_stat = ^phy_stat[ACK_BIT-1:DATA_W];
    end

endmodule

// File: rtl/phy_cr_master_chk.sv
// Property checker for phy_cr_master, attached with bind below.
// Assumes poll_interval is constant while busy.
module phy_cr_master_chk #(
    parameter int DATA_W     = 16,
    parameter int STROBE_LSB = 16,
    parameter int CTRL_W     = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              timeout_err,
    input logic [CTRL_W-1:0] phy_ctrl
);

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phy_ctrl[STROBE_LSB +: 4]));

    a_r10_value_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(phy_ctrl[DATA_W-1:0]));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    a_r7_strobes_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timeout_err) |-> (phy_ctrl[STROBE_LSB +: 4] == 4'b0000));

    a_r7_no_strobe_after: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timeout_err) |=> (phy_ctrl[STROBE_LSB +: 4] == 4'b0000));

endmodule

bind phy_cr_master phy_cr_master_chk #(
    .DATA_W     (DATA_W),
    .STROBE_LSB (STROBE_LSB),
    .CTRL_W     (CTRL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err),
    .phy_ctrl    (phy_ctrl)
);

// File: tb/sim_phy_cr_master.sv
// Bench for phy_cr_master: a PHY responder model with a programmable
// acknowledge delay and stuck modes, plus sweeps over interval and delay.
module sim_phy_cr_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_cmd = 2'b00;
    logic [15:0] req_data = '0;
    logic [7:0]  poll_interval = 8'd1;
    logic        busy, done, timeout_err;
    logic [15:0] rd_data;
    logic [19:0] phy_ctrl;
    logic [18:0] phy_stat;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    phy_cr_master u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_cmd       (req_cmd),
        .req_data      (req_data),
        .poll_interval (poll_interval),
        .busy          (busy),
        .done          (done),
        .timeout_err   (timeout_err),
        .rd_data       (rd_data),
        .phy_ctrl      (phy_ctrl),
        .phy_stat      (phy_stat)
    );

    // ---------------- PHY responder ----------------
    int          ack_delay = 1;   // 1..4 cycles
    int          ack_mode  = 0;   // 0 normal, 1 stuck low, 2 stuck high
    logic [3:0]  dly = '0;
    logic [3:0]  prev_sb = '0;
    logic [15:0] r_addr = '0;
    logic [15:0] r_data = '0;
    logic [15:0] mem [16];
    int          rises [4];
    logic        nack_reset;
    logic        ack;

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        for (int i = 0; i < 4; i++) rises[i] = 0;
    end

    assign nack_reset = phy_ctrl[18] & phy_ctrl[0];
    always_comb begin
        if (ack_mode == 1)      ack = 1'b0;
        else if (ack_mode == 2) ack = 1'b1;
        else                    ack = nack_reset ? 1'b0 : dly[ack_delay-1];
    end
    assign phy_stat = {ack, 2'b00, mem[r_addr[3:0]]};

    always @(posedge clk) begin
        dly     <= {dly[2:0], (|phy_ctrl[19:16]) & ~nack_reset};
        prev_sb <= phy_ctrl[19:16];
        for (int i = 0; i < 4; i++)
            if (phy_ctrl[16+i] && !prev_sb[i]) rises[i] = rises[i] + 1;
        if (phy_ctrl[16] && !prev_sb[0]) r_addr <= phy_ctrl[15:0];
        if (phy_ctrl[17] && !prev_sb[1]) r_data <= phy_ctrl[15:0];
        if (phy_ctrl[18] && !prev_sb[2] && !phy_ctrl[0]) mem[r_addr[3:0]] <= r_data;
    end

    // ---------------- check helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int          last_lat;
    logic        last_err;
    logic [15:0] last_rd;

    // Issue one command; optionally poke a second request while busy.
    task automatic run_cmd(input logic [1:0] c, input logic [15:0] d, input bit poke);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        if (poke) begin
            req_valid = 1'b1; req_cmd = 2'b00; req_data = 16'hFFFF;
        end
        forever begin
            if (busy) n++;
            if (done || n > 3000) break;
            @(negedge clk);
            req_valid = 1'b0;
        end
        if (n > 3000) chk(1'b0, "watchdog per-command", n, 0);
        last_lat = n;
        last_err = timeout_err;
        last_rd  = rd_data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    // Global watchdog: counts as a failure, still prints the summary.
    initial begin
        #2000000;
        chk(1'b0, "watchdog global", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int base0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && done == 0, "R1 busy/done after reset", {busy, done}, 0);
        chk(timeout_err == 0, "R1 timeout_err after reset", timeout_err, 0);
        chk(rd_data == 0, "R1 rd_data after reset", rd_data, 0);
        chk(phy_ctrl == 0, "R1 phy_ctrl after reset", phy_ctrl, 0);
        rst_n = 1'b1;
        settle();

        // R3 R4 R5 R6: sweep interval 0..3 and ack delay 1..4
        for (int iv = 0; iv < 4; iv++) begin
            for (int d = 1; d <= 4; d++) begin
                logic [15:0] a, v;
                poll_interval = 8'(iv);
                ack_delay = d;
                a = 16'((iv * 4 + d) & 15) | 16'h0A50;
                v = 16'((iv * 4 + d) * 16'h0137 + 16'h2A00) & 16'hFFFE;
                base0 = rises[0];
                run_cmd(2'b00, a, 1'b0);
                chk(!last_err, "R3 addressing no timeout", last_err, 0);
                chk(r_addr == a, "R3 address captured by PHY", r_addr, a);
                chk(rises[0] == base0 + 1, "R3 one capture-address pulse", rises[0] - base0, 1);
                chk(phy_ctrl[19:16] == 0, "R3 strobes released", phy_ctrl[19:16], 0);
                run_cmd(2'b01, v, 1'b0);
                chk(!last_err, "R4 write no timeout", last_err, 0);
                chk(mem[a[3:0]] == v, "R4 PHY register written", mem[a[3:0]], v);
                run_cmd(2'b10, 16'h0000, 1'b0);
                chk(!last_err, "R5 read no timeout", last_err, 0);
                chk(last_rd == v, "R5 read data", last_rd, v);
                chk(phy_ctrl[19] == 0, "R5 read strobe released", phy_ctrl[19], 0);
            end
        end

        // R6 R7: stuck-low ack times out after exactly 10*interval+2 busy cycles
        ack_delay = 1;
        for (int iv = 0; iv < 4; iv++) begin
            int eff;
            eff = (iv == 0) ? 1 : iv;
            poll_interval = 8'(iv);
            ack_mode = 1;
            run_cmd(2'b00, 16'h0033, 1'b0);
            chk(last_err == 1, "R7 timeout flagged", last_err, 1);
            chk(last_lat == 10 * eff + 2, "R6 timeout busy length", last_lat, 10 * eff + 2);
            chk(phy_ctrl[19:16] == 0, "R7 strobes low after timeout", phy_ctrl[19:16], 0);
            ack_mode = 0;
            settle();
        end

        // R7: stuck-high ack: the capture-data release times out; write never rises
        poll_interval = 8'd2;
        ack_mode = 2;
        base0 = rises[2];
        run_cmd(2'b01, 16'h4444, 1'b0);
        chk(last_err == 1, "R7 write release timeout", last_err, 1);
        chk(last_lat == 1 + 2 + 1 + 20 + 1, "R6 ack-then-stuck busy length", last_lat, 25);
        chk(rises[2] == base0, "R7 no write strobe after timeout", rises[2] - base0, 0);
        ack_mode = 0;
        settle();

        // R9: timeout_err clears on the next accepted command
        run_cmd(2'b00, 16'h0005, 1'b0);
        chk(last_err == 0, "R9 error cleared by next command", last_err, 0);

        // R8: reset write completes without ack and leaves the write strobe high
        poll_interval = 8'd3;
        run_cmd(2'b01, 16'h0001, 1'b0);
        chk(last_err == 0, "R8 reset write no error", last_err, 0);
        chk(phy_ctrl[18] == 1, "R8 write strobe left high", phy_ctrl[18], 1);
        chk(busy == 0, "R8 block idle after reset write", busy, 0);
        run_cmd(2'b00, 16'h0006, 1'b0);
        chk(last_err == 0 && phy_ctrl[18] == 0, "R8 strobe cleared by next command", phy_ctrl[18], 0);

        // R2: a request while busy is ignored
        poll_interval = 8'd1;
        base0 = rises[0];
        run_cmd(2'b00, 16'h0009, 1'b1);
        settle();
        chk(rises[0] == base0 + 1, "R2 no extra capture-address", rises[0] - base0, 1);
        chk(phy_ctrl[15:0] == 16'h0009, "R2 driven value unchanged", phy_ctrl[15:0], 16'h0009);
        chk(busy == 0, "R2 no second command started", busy, 0);

        // R2: code 2'b11 completes with no strobe
        base0 = rises[0] + rises[1] + rises[2] + rises[3];
        run_cmd(2'b11, 16'h1234, 1'b0);
        chk(last_err == 0 && last_lat == 2, "R2 no-op completes", last_lat, 2);
        chk(rises[0] + rises[1] + rises[2] + rises[3] == base0, "R2 no-op issues no strobe",
            rises[0] + rises[1] + rises[2] + rises[3] - base0, 0);

        // R9 R10: command length bound with ack delay 1, interval 1 (addressing)
        run_cmd(2'b00, 16'h000A, 1'b0);
        chk(last_lat >= 6 && last_lat <= 12, "R9 busy span of a short command", last_lat, 6);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule